// File: doc/BRIEF.md
# Segment Translation and Mode Arbiter

This block sits at the front of an address translator. For each access, whether an instruction fetch or a data access, it decides which translation path applies. If relocation is off for that access type, the effective address is used directly as the real address. If relocation is on, a block-translation result arrives on the same cycle from a separate unit, and it wins whenever it hits. Otherwise the block uses one of sixteen segment entries, picked by the top four effective-address bits.

For an ordinary segment, the block builds a 52-bit virtual address. It also picks the storage key that matches the privilege state. It then issues a page-table search request on a valid/ready channel. The walk that serves this request lives elsewhere.

A direct-store segment never goes to the page table. A data access to one is reported as an I/O access. A fetch from one is reported as an instruction storage fault.

Every accepted access produces exactly one outcome one clock later. That outcome is either a resolved result on the result port or a search request. While a search request is waiting to be accepted, new accesses are held off.

Top module: `seg_xlate_arb`

## Requirements
- R1: After reset, `res_valid` and `pt_valid` are 0 and `acc_ready` is 1.
- R2: The state-register bits are numbered with bit 0 as the MSB. A fetch with instruction relocate (bit 26, `msr[5]`) at 0 resolves as kind REAL (2'b00) with `res_ra` equal to the effective address. A data access does the same when data relocate (bit 27, `msr[4]`) is 0. Each bit affects only its own access type.
- R3: With relocation on for the access type, a block-translation hit resolves as kind BLOCK (2'b01) with `res_ra = bat_ra`. This holds whatever the selected segment entry contains, including a direct-store entry.
- R4: The segment entry is selected by `acc_ea[31:28]`. Each entry is loaded through `sr_we`/`sr_waddr`/`sr_wdata`, and a write affects only accesses accepted after the write edge. The entry layout is: type `[31]` (1 = direct-store), supervisor key `[30]`, user key `[29]`, segment ID `[23:0]`.
- R5: With relocation on, no block hit and an ordinary entry, the block raises `pt_valid` with `pt_va = {segment ID, acc_ea[27:12], acc_ea[11:0]}` and `pt_fetch` set to the access type. No result is produced for that access.
- R6: `pt_key` is the user key when state bit 17 (`msr[14]`) is 1, and the supervisor key otherwise.
- R7: With relocation on and no block hit, a fetch to a direct-store entry resolves as kind ISF (2'b11), the instruction storage fault.
- R8: With relocation on and no block hit, a data access to a direct-store entry resolves as kind IO (2'b10) with `res_ra` equal to the effective address. No search request is made.
- R9: While `pt_valid` is 1 and `pt_ready` is 0, `pt_va`, `pt_key` and `pt_fetch` stay stable, `pt_valid` stays 1, and `acc_ready` is 0.
- R10: An access accepted on one edge (`acc_valid & acc_ready`) produces exactly one of `res_valid` or `pt_valid` after that edge, never both. No outcome appears without an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msr | input | 32 | Machine state; bit 0 is the MSB |
| sr_we | input | 1 | Segment entry write enable |
| sr_waddr | input | 4 | Segment entry write index |
| sr_wdata | input | 32 | Segment entry write data |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Access can be accepted |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_ea | input | 32 | Effective address |
| bat_hit | input | 1 | Block translation hit for this access |
| bat_ra | input | 32 | Block translation real address |
| res_valid | output | 1 | Resolved outcome valid (one cycle) |
| res_kind | output | 2 | 00 REAL, 01 BLOCK, 10 IO, 11 ISF |
| res_ra | output | 32 | Resolved real address |
| pt_valid | output | 1 | Page-table search request |
| pt_ready | input | 1 | Request accepted |
| pt_va | output | 52 | Virtual address to search |
| pt_key | output | 1 | Selected storage key |
| pt_fetch | output | 1 | Request comes from a fetch |

## Verification
The assertions assume several things about the inputs. The block-translation inputs are valid in the same cycle as the access they belong to. `msr` and the effective address are sampled only on the accepting edge. `pt_ready` may be driven at any time, but it is only significant while `pt_valid` is high.

The stimulus keeps to these assumptions. It drives all access inputs away from the clock edge and presents them for exactly one accepting edge. It waits for each search request to be accepted before offering the next access. It also holds `pt_ready` low for a random number of cycles, so the stall behaviour is exercised.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int EA_W     = 32;
  parameter int NUM_SEG  = 16;
  parameter int SEG_IW   = $clog2(NUM_SEG);
  parameter int VSID_W   = 24;
  parameter int OFF_W    = 12;
  parameter int PIDX_W   = EA_W - SEG_IW - OFF_W;
  parameter int VA_W     = VSID_W + PIDX_W + OFF_W;
  parameter int SR_W     = 32;

  // big-endian architectural bit b maps to vector index 31-b
  localparam int MSR_USER_IDX = 31 - 17;
  localparam int MSR_IR_IDX   = 31 - 26;
  localparam int MSR_DR_IDX   = 31 - 27;
  localparam int SR_TYPE_IDX  = 31;
  localparam int SR_KSUP_IDX  = 30;
  localparam int SR_KUSR_IDX  = 29;

  typedef enum logic [1:0] {
    KIND_REAL  = 2'b00,
    KIND_BLOCK = 2'b01,
    KIND_IO    = 2'b10,
    KIND_ISF   = 2'b11
  } xl_kind_e;

  typedef struct packed {
    logic            to_pt;
    xl_kind_e        kind;
    logic [EA_W-1:0] ra;
    logic [VA_W-1:0] va;
    logic            key;
    logic            fetch;
  } xl_dec_t;
endpackage

// File: rtl/sxa_segfile.sv
module sxa_segfile
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_IW-1:0] wr_idx,
  input  logic [SR_W-1:0]   wr_data,
  input  logic [SEG_IW-1:0] rd_idx,
  output logic [SR_W-1:0]   rd_data
);
  logic [SR_W-1:0] entry_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic            ld;
    logic [SR_W-1:0] entry_d;
    always_comb begin
      ld      = wr_en && (wr_idx == SEG_IW'(g));
      entry_d = ld ? wr_data : entry_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[g] <= '0;
      else        entry_q[g] <= entry_d;
    end
  end

  assign rd_data = entry_q[rd_idx];

  AST_SR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> entry_q[$past(wr_idx)] == $past(wr_data)); // R4
endmodule

// File: rtl/sxa_route.sv
module sxa_route
  import seg_xlate_pkg::*;
(
  input  logic            fetch,
  input  logic [EA_W-1:0] ea,
  input  logic [31:0]     msr,
  input  logic            bat_hit,
  input  logic [EA_W-1:0] bat_ra,
  input  logic [SR_W-1:0] seg,
  output xl_dec_t         dec
);
  logic reloc;
  logic user;
  logic dstore;
  logic sel_key;

  always_comb begin
    reloc   = fetch ? msr[MSR_IR_IDX] : msr[MSR_DR_IDX];
    user    = msr[MSR_USER_IDX];
    dstore  = seg[SR_TYPE_IDX];
    sel_key = user ? seg[SR_KUSR_IDX] : seg[SR_KSUP_IDX];

    dec.to_pt = 1'b0;
    dec.kind  = KIND_REAL;
    dec.ra    = ea;
    dec.va    = {seg[VSID_W-1:0], ea[EA_W-SEG_IW-1:0]};
    dec.key   = sel_key;
    dec.fetch = fetch;

    if (!reloc) begin
      dec.kind = KIND_REAL;
    end else if (bat_hit) begin
      dec.kind = KIND_BLOCK;
      dec.ra   = bat_ra;
    end else if (dstore) begin
      dec.kind = fetch ? KIND_ISF : KIND_IO;
    end else begin
      dec.to_pt = 1'b1;
    end
  end
endmodule

// File: rtl/sxa_outstage.sv
module sxa_outstage
  import seg_xlate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  xl_dec_t         dec,
  output logic            res_valid,
  output logic [1:0]      res_kind,
  output logic [EA_W-1:0] res_ra,
  output logic            pt_valid,
  input  logic            pt_ready,
  output logic [VA_W-1:0] pt_va,
  output logic            pt_key,
  output logic            pt_fetch,
  output logic            can_take
);
  logic            res_v_q, res_v_d;
  xl_kind_e        kind_q;
  logic [EA_W-1:0] ra_q;
  logic            pt_v_q, pt_v_d;
  logic [VA_W-1:0] va_q;
  logic            key_q, fch_q;
  logic            res_ld, pt_ld;

  always_comb begin
    can_take = !pt_v_q || pt_ready;
    res_ld   = fire && !dec.to_pt;
    pt_ld    = fire && dec.to_pt;
    res_v_d  = res_ld;
    pt_v_d   = pt_v_q;
    if (pt_v_q && pt_ready) pt_v_d = 1'b0;
    if (pt_ld)              pt_v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_v_q <= 1'b0;
      pt_v_q  <= 1'b0;
    end else begin
      res_v_q <= res_v_d;
      pt_v_q  <= pt_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_REAL;
      ra_q   <= '0;
    end else if (res_ld) begin
      kind_q <= dec.kind;
      ra_q   <= dec.ra;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      key_q <= 1'b0;
      fch_q <= 1'b0;
    end else if (pt_ld) begin
      va_q  <= dec.va;
      key_q <= dec.key;
      fch_q <= dec.fetch;
    end
  end

  assign res_valid = res_v_q;
  assign res_kind  = kind_q;
  assign res_ra    = ra_q;
  assign pt_valid  = pt_v_q;
  assign pt_va     = va_q;
  assign pt_key    = key_q;
  assign pt_fetch  = fch_q;

  AST_PT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pt_v_q && !pt_ready |=> pt_v_q && $stable(va_q) && $stable(key_q) && $stable(fch_q)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_v_q && pt_v_q)); // R10
  AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !res_v_q); // R10
endmodule

// File: rtl/seg_xlate_arb.sv
module seg_xlate_arb
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] msr,
  input  logic        sr_we,
  input  logic [3:0]  sr_waddr,
  input  logic [31:0] sr_wdata,
  input  logic        acc_valid,
  output logic        acc_ready,
  input  logic        acc_fetch,
  input  logic [31:0] acc_ea,
  input  logic        bat_hit,
  input  logic [31:0] bat_ra,
  output logic        res_valid,
  output logic [1:0]  res_kind,
  output logic [31:0] res_ra,
  output logic        pt_valid,
  input  logic        pt_ready,
  output logic [51:0] pt_va,
  output logic        pt_key,
  output logic        pt_fetch
);
  logic [SR_W-1:0] seg_word;
  xl_dec_t         dec;
  logic            fire;

  sxa_segfile u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sr_we),
    .wr_idx  (sr_waddr),
    .wr_data (sr_wdata),
    .rd_idx  (acc_ea[EA_W-1 -: SEG_IW]),
    .rd_data (seg_word)
  );

  sxa_route u_route (
    .fetch   (acc_fetch),
    .ea      (acc_ea),
    .msr     (msr),
    .bat_hit (bat_hit),
    .bat_ra  (bat_ra),
    .seg     (seg_word),
    .dec     (dec)
  );

  assign fire = acc_valid && acc_ready;

  sxa_outstage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .dec       (dec),
    .res_valid (res_valid),
    .res_kind  (res_kind),
    .res_ra    (res_ra),
    .pt_valid  (pt_valid),
    .pt_ready  (pt_ready),
    .pt_va     (pt_va),
    .pt_key    (pt_key),
    .pt_fetch  (pt_fetch),
    .can_take  (acc_ready)
  );

  AST_REAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !(acc_fetch ? msr[MSR_IR_IDX] : msr[MSR_DR_IDX])
    |=> res_valid && res_kind == KIND_REAL && res_ra == $past(acc_ea)); // R2
  AST_BLOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (acc_fetch ? msr[MSR_IR_IDX] : msr[MSR_DR_IDX]) && bat_hit
    |=> res_valid && res_kind == KIND_BLOCK && res_ra == $past(bat_ra)); // R3
  AST_DSTORE_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    fire && seg_word[SR_TYPE_IDX] |=> !pt_valid); // R7
  AST_FETCH_NEVER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && acc_fetch |=> !(res_valid && res_kind == KIND_IO)); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && !pt_ready |-> !acc_ready); // R9
endmodule

// File: tb/sim_seg_xlate_arb.sv
module sim_seg_xlate_arb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] msr;
  logic        sr_we;
  logic [3:0]  sr_waddr;
  logic [31:0] sr_wdata;
  logic        acc_valid, acc_ready, acc_fetch;
  logic [31:0] acc_ea;
  logic        bat_hit;
  logic [31:0] bat_ra;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [31:0] res_ra;
  logic        pt_valid, pt_ready, pt_key, pt_fetch;
  logic [51:0] pt_va;

  int checks = 0;
  int fails  = 0;
  logic [31:0] shadow [16];

  always #10 clk = ~clk;

  seg_xlate_arb u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_outcome(input logic f, input logic [31:0] m,
                                             input logic [31:0] ea, input logic hit);
    // {to_pt, kind}
    logic rel = f ? m[5] : m[4];
    logic [31:0] s = shadow[ea[31:28]];
    if (!rel) return {1'b0, 2'b00};
    if (hit)  return {1'b0, 2'b01};
    if (s[31]) return {1'b0, f ? 2'b11 : 2'b10};
    return {1'b1, 2'b00};
  endfunction

  task automatic wr_seg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sr_we = 1'b1; sr_waddr = a; sr_wdata = d;
    @(negedge clk);
    sr_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic access(input logic f, input logic [31:0] m, input logic [31:0] ea,
                        input logic hit, input logic [31:0] bra, input int stall);
    logic [2:0]  e;
    logic [31:0] s;
    logic [51:0] va_e;
    logic        key_e;
    e = exp_outcome(f, m, ea, hit);
    s = shadow[ea[31:28]];
    va_e  = {s[23:0], ea[27:0]};
    key_e = m[14] ? s[29] : s[30];
    acc_valid = 1'b1; acc_fetch = f; msr = m; acc_ea = ea; bat_hit = hit; bat_ra = bra;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    if (!e[2]) begin
      chk("R10", {62'd0, res_valid, pt_valid}, 64'd2);
      case (e[1:0])
        2'b00: begin chk("R2", res_kind, 0); chk("R2", res_ra, ea); end
        2'b01: begin chk("R3", res_kind, 1); chk("R3", res_ra, bra); end
        2'b10: begin chk("R8", res_kind, 2); chk("R8", res_ra, ea); end
        default: chk("R7", res_kind, 3);
      endcase
    end else begin
      chk("R10", {62'd0, res_valid, pt_valid}, 64'd1);
      chk("R5", pt_va, va_e);
      chk("R5", pt_fetch, f);
      chk("R6", pt_key, key_e);
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        chk("R9", {pt_valid, acc_ready, pt_key, pt_fetch}, {2'b10, key_e, f});
        chk("R9", pt_va, va_e);
      end
      pt_ready = 1'b1;
      @(negedge clk);
      pt_ready = 1'b0;
      chk("R9", pt_valid, 0);
    end
  endtask

  initial begin
    logic [31:0] m;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; msr = '0; sr_we = 0; sr_waddr = '0; sr_wdata = '0;
    acc_valid = 0; acc_fetch = 0; acc_ea = '0; bat_hit = 0; bat_ra = '0; pt_ready = 0;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {res_valid, pt_valid, acc_ready}, 3'b001);

    // directed corners
    wr_seg(4'h3, {1'b0, 1'b1, 1'b0, 5'd0, 24'hABCDEF});  // ordinary, Ks=1 Kp=0
    wr_seg(4'h7, {1'b1, 1'b0, 1'b1, 5'd0, 24'h123456});  // direct-store
    m = 32'h0000_0030;                               // IR and DR on, supervisor
    access(1'b0, m, 32'h3123_4567, 1'b0, '0, 2);      // R5/R6 supervisor key
    access(1'b0, m | 32'h4000, 32'h3FFF_F001, 1'b0, '0, 0); // R6 user key
    access(1'b1, m, 32'h7000_0010, 1'b0, '0, 0);      // R7 fetch to direct-store
    access(1'b0, m, 32'h7000_0020, 1'b0, '0, 0);      // R8 I/O
    access(1'b0, m, 32'h7000_0030, 1'b1, 32'h0055_0000, 0); // R3 over direct-store
    access(1'b1, 32'h0000_0010, 32'h3000_0040, 1'b1, 32'h1, 0); // R2 IR off, DR on
    access(1'b0, 32'h0000_0020, 32'h3000_0044, 1'b0, '0, 0);    // R2 DR off, IR on
    access(1'b1, 32'h0000_0020, 32'h3000_0048, 1'b0, '0, 1);    // R2 IR on -> walk
    // R4: write and use on the next access
    wr_seg(4'h3, {1'b1, 2'b00, 5'd0, 24'h0});
    access(1'b0, m, 32'h3000_0050, 1'b0, '0, 0);      // R4 now direct-store -> IO

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0)
        wr_seg(4'($urandom_range(0, 15)), $urandom());
      access(1'($urandom_range(0, 1)), $urandom() & 32'h0000_4030, $urandom(),
             ($urandom_range(0, 9) < 3), $urandom(), $urandom_range(0, 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule